// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Data Memory

This block is a synchronous data store in which every byte has its own address. A single request port carries an address, a size code and a write flag. One request reads or writes a byte, a 16-bit word or a 32-bit longword. A multi-byte value is laid out with its most significant byte at the lowest address. Internally the store is split into four byte-wide banks, one for each value of the two low address bits. Each bank is built so that it maps onto block RAM. The lane logic steers each byte of a value to the right bank, and to the right row within that bank. Because of this, a longword that starts two bytes into a 32-bit row can span two rows and still complete in a single cycle.

A word or longword request at an odd address is refused. An unsupported size code is refused in the same way. A refused request leaves the store unchanged and raises an error flag for one cycle. A refused read still returns a response, with zero data. A separate preload port writes single bytes, so a test environment can place constants before a program runs. Addresses wrap at the top of the store.

Top module: `bytemem_be`

## Requirements
- R1: After a synchronous active-high reset, `rd_valid` and `align_err` are low and `rd_data` is zero until the first request.
- R2: A byte request (`acc_size` = 0) writes `wr_data[7:0]` to the addressed cell. A byte read returns the cell in `rd_data[7:0]`, with `rd_data[31:8]` zero. The result appears with `rd_valid` high in the cycle after the request.
- R3: A longword request (`acc_size` = 2) stores `wr_data[31:24]` at the start address and each lower byte at the next higher address. A longword read returns the bytes reassembled in the same order in `rd_data[31:0]`.
- R4: A word request (`acc_size` = 1) at an even address stores `wr_data[15:8]` at the address and `wr_data[7:0]` at the address plus one. A word read returns the word in `rd_data[15:0]`, with the upper half zero.
- R5: A longword request at an even address that is not a multiple of four is accepted and spans two 32-bit rows.
- R6: A word or longword write at an odd address raises `align_err` for exactly the one cycle after the request and changes no byte of the store.
- R7: A word or longword read at an odd address answers in the next cycle with `rd_valid` and `align_err` both high and `rd_data` zero.
- R8: Size code 3 is refused in the same way as a misaligned request: error flag set, store unchanged.
- R9: While `pre_we` is high, `pre_data` is written to the byte at `pre_addr`. Any request in that cycle is ignored: no store change, no `rd_valid` and no `align_err` in the next cycle.
- R10: Byte addresses wrap modulo the store depth. A longword at depth minus 2 occupies the last two bytes and then bytes 0 and 1.
- R11: A byte write leaves the neighbouring bytes of the same 32-bit row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Request strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 word, 2 longword, 3 invalid |
| acc_addr | input | ADDR_W | Byte address of the most significant byte |
| wr_data | input | 32 | Write value, right-justified |
| pre_we | input | 1 | Preload strobe |
| pre_addr | input | ADDR_W | Preload byte address |
| pre_data | input | 8 | Preload byte |
| rd_data | output | 32 | Read value, right-justified, zero when not valid |
| rd_valid | output | 1 | Read response present |
| align_err | output | 1 | Request refused in the previous cycle |

## Verification
The tests first use each size at an address that is a multiple of four. Byte reads after a longword write show the byte order, which a lane swap or a reversed layout would break. A longword at an address that is two past a multiple of four, and another at the top of the store, exercise the row-carry and wrap paths that aligned tests never reach. Misaligned requests, invalid-size requests and requests that collide with preload writes are each followed by a read-back of the bytes they could have touched, which separates "flagged" from "flagged and harmless". A single byte write inside a known longword shows that writes are masked per lane.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  localparam int LANES = 4;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      SZ_LONG: size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bytemem_bank.sv
module bytemem_bank #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);
  localparam int ROWS = 1 << ROW_W;

  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wbyte;
    rbyte <= mem[row];
  end
endmodule

// File: rtl/bytemem_lane_ctl.sv
module bytemem_lane_ctl #(
  parameter int ADDR_W = 12,
  parameter int LANE   = 0,
  localparam int ROW_W = ADDR_W - 2
) (
  input  logic              go,
  input  logic              wr,
  input  logic [2:0]        nbytes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_data,
  output logic              lane_we,
  output logic [ROW_W-1:0]  lane_row,
  output logic [7:0]        lane_byte
);
  logic [1:0]        k;
  logic [2:0]        sh;
  logic [ADDR_W-1:0] baddr;
  logic [31:0]       shifted;
  logic              hit;

  always_comb begin
    k       = 2'(LANE) - addr[1:0];
    hit     = go && ({1'b0, k} < nbytes);
    baddr   = addr + ADDR_W'(k);
    sh      = nbytes - 3'd1 - {1'b0, k};
    shifted = wdata >> {sh, 3'b000};
    if (pre_we) begin
      lane_we   = (pre_addr[1:0] == 2'(LANE));
      lane_row  = pre_addr[ADDR_W-1:2];
      lane_byte = pre_data;
    end else begin
      lane_we   = hit && wr;
      lane_row  = baddr[ADDR_W-1:2];
      lane_byte = shifted[7:0];
    end
  end
endmodule

// File: rtl/bytemem_rd_pack.sv
module bytemem_rd_pack (
  input  logic [3:0][7:0] lane_q,
  input  logic [2:0]      nbytes,
  input  logic [1:0]      off,
  output logic [31:0]     value
);
  always_comb begin
    value = '0;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < nbytes) begin
        value = value | (32'(lane_q[2'(off + 2'(k))]) << (8 * (int'(nbytes) - 1 - k)));
      end
    end
  end
endmodule

// File: rtl/bytemem_be.sv
module bytemem_be
  import bytemem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       wr_data,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_data,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              align_err
);
  localparam int ROW_W = ADDR_W - 2;

  logic             taken, refused, go;
  logic [2:0]       nbytes;
  logic [2:0]       n_q;
  logic [1:0]       off_q;
  logic             rv_q, err_q;
  logic [3:0][7:0]  lane_q;
  logic [31:0]      packed_val;

  always_comb begin
    nbytes  = size_bytes(acc_size);
    taken   = acc_req && !pre_we;
    refused = (acc_size == SZ_BAD) || ((acc_size != SZ_BYTE) && acc_addr[0]);
    go      = taken && !refused;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic             we_i;
    logic [ROW_W-1:0] row_i;
    logic [7:0]       byte_i;

    bytemem_lane_ctl #(.ADDR_W(ADDR_W), .LANE(i)) u_ctl (
      .go       (go),
      .wr       (acc_we),
      .nbytes   (nbytes),
      .addr     (acc_addr),
      .wdata    (wr_data),
      .pre_we   (pre_we),
      .pre_addr (pre_addr),
      .pre_data (pre_data),
      .lane_we  (we_i),
      .lane_row (row_i),
      .lane_byte(byte_i)
    );

    bytemem_bank #(.ROW_W(ROW_W)) u_bank (
      .clk  (clk),
      .we   (we_i),
      .row  (row_i),
      .wbyte(byte_i),
      .rbyte(lane_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q  <= 1'b0;
      err_q <= 1'b0;
      n_q   <= '0;
      off_q <= '0;
    end else begin
      rv_q  <= taken && !acc_we;
      err_q <= taken && refused;
      n_q   <= nbytes;
      off_q <= acc_addr[1:0];
    end
  end

  bytemem_rd_pack u_pack (
    .lane_q(lane_q),
    .nbytes(n_q),
    .off   (off_q),
    .value (packed_val)
  );

  assign rd_valid  = rv_q;
  assign align_err = err_q;
  assign rd_data   = (rv_q && !err_q) ? packed_val : 32'd0;
endmodule

// File: rtl/bytemem_be_chk.sv
module bytemem_be_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_req,
  input logic              acc_we,
  input logic [1:0]        acc_size,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              pre_we,
  input logic [31:0]       rd_data,
  input logic              rd_valid,
  input logic              align_err
);
  // R6
  misalign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !pre_we && acc_size != 2'd0 && acc_addr[0]) |=> align_err);

  // R6
  clean_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !pre_we && acc_size != 2'd3 && (acc_size == 2'd0 || !acc_addr[0])) |=> !align_err);

  // R7
  refused_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && align_err) |-> (rd_data == 32'd0));

  // R2
  read_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !pre_we && !acc_we) |=> rd_valid);

  // R2
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !pre_we && !acc_we && acc_size == 2'd0) |=> (rd_data[31:8] == 24'd0));

  // R4
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !pre_we && !acc_we && acc_size == 2'd1) |=> (rd_data[31:16] == 16'd0));

  // R9
  preload_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    pre_we |=> (!rd_valid && !align_err));

  // R8
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !pre_we && acc_size == 2'd3) |=> align_err);
endmodule

bind bytemem_be bytemem_be_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_req  (acc_req),
  .acc_we   (acc_we),
  .acc_size (acc_size),
  .acc_addr (acc_addr),
  .pre_we   (pre_we),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .align_err(align_err)
);

// File: tb/bytemem_be_tb.sv
module bytemem_be_tb;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              acc_req = 1'b0, acc_we = 1'b0;
  logic [1:0]        acc_size = 2'd0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              pre_we = 1'b0;
  logic [ADDR_W-1:0] pre_addr = '0;
  logic [7:0]        pre_data = '0;
  logic [31:0]       rd_data;
  logic              rd_valid, align_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bytemem_be #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_we(acc_we),
    .acc_size(acc_size), .acc_addr(acc_addr), .wr_data(wr_data),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .align_err(align_err)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // Drive one request for one cycle; outputs sampled at the next falling edge.
  task automatic access(input logic we, input logic [1:0] sz, input int a,
                        input logic [31:0] d,
                        output logic [31:0] q, output logic v, output logic e);
    @(negedge clk);
    acc_req = 1'b1; acc_we = we; acc_size = sz;
    acc_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    acc_req = 1'b0; acc_we = 1'b0;
    q = rd_data; v = rd_valid; e = align_err;
  endtask

  task automatic wr(input logic [1:0] sz, input int a, input logic [31:0] d);
    logic [31:0] q; logic v, e;
    access(1'b1, sz, a, d, q, v, e);
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sz, input int a, input logic [31:0] exp);
    logic [31:0] q; logic v, e;
    access(1'b0, sz, a, 32'd0, q, v, e);
    chk({tag, " valid"}, {31'd0, v}, 32'd1);
    chk({tag, " data"}, q, exp);
  endtask

  task automatic preload(input int a, input logic [7:0] b);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = ADDR_W'(a); pre_data = b;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 align_err", {31'd0, align_err}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
  endtask

  task automatic t_bytes();
    for (int i = 0; i < 4; i++) wr(2'd0, 16 + i, 32'hFFFF_FFA0 + 32'(i));
    for (int i = 0; i < 4; i++) rd_chk("R2 byte", 2'd0, 16 + i, 32'h0000_00A0 + 32'(i));
  endtask

  task automatic t_long_order();
    wr(2'd2, 4, 32'h000A_1234);
    rd_chk("R3 b4", 2'd0, 4, 32'h00);
    rd_chk("R3 b5", 2'd0, 5, 32'h0A);
    rd_chk("R3 b6", 2'd0, 6, 32'h12);
    rd_chk("R3 b7", 2'd0, 7, 32'h34);
    rd_chk("R3 long", 2'd2, 4, 32'h000A_1234);
  endtask

  task automatic t_word();
    wr(2'd1, 32, 32'hDEAD_BEEF);
    rd_chk("R4 hi", 2'd0, 32, 32'hBE);
    rd_chk("R4 lo", 2'd0, 33, 32'hEF);
    rd_chk("R4 word", 2'd1, 32, 32'h0000_BEEF);
    wr(2'd1, 34, 32'h0000_5AA5);
    rd_chk("R4 word off2", 2'd1, 34, 32'h0000_5AA5);
  endtask

  task automatic t_span();
    wr(2'd2, 66, 32'hCAFE_F00D);
    rd_chk("R5 b66", 2'd0, 66, 32'hCA);
    rd_chk("R5 b69", 2'd0, 69, 32'h0D);
    rd_chk("R5 long", 2'd2, 66, 32'hCAFE_F00D);
  endtask

  task automatic t_misalign_wr();
    logic [31:0] q; logic v, e;
    access(1'b1, 2'd2, 5, 32'hFFFF_FFFF, q, v, e);
    chk("R6 err", {31'd0, e}, 32'd1);
    chk("R6 no valid", {31'd0, v}, 32'd0);
    @(negedge clk);
    chk("R6 one cycle", {31'd0, align_err}, 32'd0);
    rd_chk("R6 unchanged", 2'd2, 4, 32'h000A_1234);
    access(1'b1, 2'd1, 33, 32'h0000_1111, q, v, e);
    chk("R6 word err", {31'd0, e}, 32'd1);
    rd_chk("R6 word unchanged", 2'd1, 32, 32'h0000_BEEF);
  endtask

  task automatic t_misalign_rd();
    logic [31:0] q; logic v, e;
    access(1'b0, 2'd1, 33, 32'd0, q, v, e);
    chk("R7 valid", {31'd0, v}, 32'd1);
    chk("R7 err", {31'd0, e}, 32'd1);
    chk("R7 zero", q, 32'd0);
  endtask

  task automatic t_bad_size();
    logic [31:0] q; logic v, e;
    access(1'b1, 2'd3, 32, 32'h1234_5678, q, v, e);
    chk("R8 err", {31'd0, e}, 32'd1);
    rd_chk("R8 unchanged", 2'd2, 32, 32'hBEEF_5AA5);
  endtask

  task automatic t_preload();
    preload(80, 8'h77);
    preload(81, 8'h00);
    rd_chk("R9 preload", 2'd1, 80, 32'h0000_7700);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = ADDR_W'(82); pre_data = 8'h3C;
    acc_req = 1'b1; acc_we = 1'b1; acc_size = 2'd0;
    acc_addr = ADDR_W'(81); wr_data = 32'h99;
    @(negedge clk);
    pre_we = 1'b0; acc_req = 1'b0; acc_we = 1'b0;
    chk("R9 no valid", {31'd0, rd_valid}, 32'd0);
    chk("R9 no err", {31'd0, align_err}, 32'd0);
    rd_chk("R9 ignored", 2'd0, 81, 32'h00);
    rd_chk("R9 written", 2'd0, 82, 32'h3C);
  endtask

  task automatic t_wrap();
    wr(2'd2, DEPTH - 2, 32'h1122_3344);
    rd_chk("R10 top", 2'd0, DEPTH - 2, 32'h11);
    rd_chk("R10 last", 2'd0, DEPTH - 1, 32'h22);
    rd_chk("R10 zero", 2'd0, 0, 32'h33);
    rd_chk("R10 one", 2'd0, 1, 32'h44);
    rd_chk("R10 long", 2'd2, DEPTH - 2, 32'h1122_3344);
  endtask

  task automatic t_byte_mask();
    wr(2'd0, 6, 32'h0000_0055);
    rd_chk("R11 masked", 2'd2, 4, 32'h000A_5534);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_long_order();
    t_word();
    t_span();
    t_misalign_wr();
    t_misalign_rd();
    t_bad_size();
    t_preload();
    t_wrap();
    t_byte_mask();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog got=%08h exp=%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule